// File: doc/BRIEF.md
# Calendar Alarm Comparator and Interrupt Flag Unit

This block watches the current minute, hour, day-of-month and weekday of a real-time clock and compares them with four programmable alarm fields. Each alarm field carries an active-low enable in its top bit. When every enabled field agrees with the running time, the combined match rises and the alarm flag is raised on that one cycle. The flag is not raised again while the match simply persists.

The unit also holds the timer flag, which a one-cycle expiry strobe from the countdown timer sets. It holds the two interrupt enables and a pulse-mode select as well. From these it drives a registered, active-low interrupt line. A host clears the flags through a control write. The flag bits of that write are ANDed into the stored flags: a 0 clears a flag and a 1 leaves it as it was. The enable and mode bits of the same write are loaded directly. The time counters and the serial bus sit outside this block.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After synchronous reset, ctrl_q reads 0, each byte of alarm_q reads 0x80 (enable bit 7 set, so every field is excluded), and int_n is 1.
- R2: Alarm registers are selected by wr_sel 1 (minute, low 7 bits compared), 2 (hour, low 6 bits), 3 (day, low 6 bits) and 4 (weekday, low 3 bits). Bit 7 = 0 includes the field in the comparison; bit 7 = 1 excludes it. alarm_q packs them as {weekday, day, hour, minute}.
- R3: The alarm flag (ctrl_q bit 0) becomes 1 after the clock edge at which the combined match goes from false to true. The combined match is true when all enabled fields equal the current time.
- R4: When no alarm field is enabled, the combined match is false and the alarm flag never sets.
- R5: After the alarm flag has been cleared while the match still holds, it stays 0. It sets again only on a new false-to-true transition of the match.
- R6: A one-cycle tmr_expire pulse sets the timer flag (ctrl_q bit 1) after that clock edge.
- R7: A write with wr_sel 0 ANDs wr_data bits 0 and 1 into the alarm and timer flags. The same write loads bit 2 (alarm interrupt enable), bit 3 (timer interrupt enable) and bit 4 (pulse mode) as written.
- R8: When a flag's set event falls in the same cycle as a write clearing that flag, the flag ends at 1.
- R9: In level mode (bit 4 = 0), int_n is 0 whenever (alarm enable AND alarm flag) OR (timer enable AND timer flag), and 1 otherwise.
- R10: In pulse mode, the timer term is (timer enable AND tmr_pulse) and the timer flag is ignored. The alarm term stays level, so int_n remains 0 while the alarm flag and alarm enable are both 1.
- R11: int_n is registered: it reflects the flags, enables and tmr_pulse of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday, 0 to 6 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 control, 1 to 4 alarm fields |
| wr_data | input | 8 | Write data |
| tmr_expire | input | 1 | One-cycle countdown expiry strobe |
| tmr_pulse | input | 1 | Pulse-shaped timer interrupt request |
| ctrl_q | output | 5 | Control readback: {pulse, timer enable, alarm enable, timer flag, alarm flag} |
| alarm_q | output | 32 | Alarm register readback {weekday, day, hour, minute} |
| int_n | output | 1 | Registered active-low interrupt |

## Verification
A new match can rise in the same cycle that a host write clears the alarm flag. The same collision exists between a timer expiry and a write clearing the timer flag. The bench provokes both by presenting the matching time, or the expiry strobe, on the very cycle of the clearing write. It judges the outcome by requiring the flag to read 1 afterwards. A sweep over all sixteen enable masks against all sixteen field-equality patterns settles the comparison itself, with the expected flag computed from the mask and pattern.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int REG_W      = 8;
  localparam int EN_BIT     = REG_W - 1;

  // control register bit positions
  localparam int C_AF    = 0;
  localparam int C_TF    = 1;
  localparam int C_AIE   = 2;
  localparam int C_TIE   = 3;
  localparam int C_PULSE = 4;
  localparam int CTRL_W  = 5;

  typedef logic [REG_W-1:0] areg_t;

  // compared width of each time field: minute, hour, day, weekday
  function automatic int fld_width(input int idx);
    case (idx)
      0:       return 7;
      1:       return 6;
      2:       return 6;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  areg_t                       cur [NUM_FIELDS],
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  areg_t                       wr_data,
  output logic [NUM_FIELDS*REG_W-1:0] alarm_q,
  output logic                        match_rise
);
  areg_t                 areg [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fld_en;
  logic [NUM_FIELDS-1:0] fld_hit;
  logic                  match_all;
  logic                  match_prev;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam areg_t CMP_MASK = areg_t'((1 << fld_width(i)) - 1);

    always_ff @(posedge clk) begin
      if (rst)
        areg[i] <= areg_t'(1) << EN_BIT;
      else if (wr_en && wr_sel == SEL_W'(i + 1))
        areg[i] <= wr_data;
    end

    assign fld_en[i]  = ~areg[i][EN_BIT];
    assign fld_hit[i] = ~fld_en[i] | (((areg[i] ^ cur[i]) & CMP_MASK) == '0);
    assign alarm_q[i*REG_W +: REG_W] = areg[i];
  end

  assign match_all  = (|fld_en) & (&fld_hit);
  assign match_rise = match_all & ~match_prev;

  always_ff @(posedge clk) begin
    if (rst) match_prev <= 1'b0;
    else     match_prev <= match_all;
  end

  // R4: with every field excluded no match may be reported
  a_r4_no_field_no_match: assert property (@(posedge clk) disable iff (rst)
    (fld_en == '0) |-> !match_rise);
  // R5: a match that merely persists does not produce a second rise
  a_r5_single_rise: assert property (@(posedge clk) disable iff (rst)
    match_rise |=> !match_rise);
endmodule

// File: rtl/rtc_flag_regs.sv
module rtc_flag_regs
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  areg_t             wr_data,
  input  logic              alarm_set,
  input  logic              timer_set,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      // flags: ANDed on write, a set event in the same cycle wins
      ctrl_q[C_AF] <= (ctrl_q[C_AF] & ~(wr_ctrl & ~wr_data[C_AF])) | alarm_set;
      ctrl_q[C_TF] <= (ctrl_q[C_TF] & ~(wr_ctrl & ~wr_data[C_TF])) | timer_set;
      if (wr_ctrl) begin
        ctrl_q[C_AIE]   <= wr_data[C_AIE];
        ctrl_q[C_TIE]   <= wr_data[C_TIE];
        ctrl_q[C_PULSE] <= wr_data[C_PULSE];
      end
    end
  end

  // R3: the alarm flag only rises after a match edge
  a_r3_af_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[C_AF]) |-> $past(alarm_set));
  // R6: the timer flag only rises after an expiry strobe
  a_r6_tf_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[C_TF]) |-> $past(timer_set));
  // R7: a flag only falls after a control write carrying 0 for it
  a_r7_af_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_q[C_AF]) |-> $past(wr_ctrl && !wr_data[C_AF]));
  // R8: a set event always leaves the flag high
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    timer_set |=> ctrl_q[C_TF]);
endmodule

// File: rtl/rtc_irq_out.sv
module rtc_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic af,
  input  logic tf,
  input  logic aie,
  input  logic tie,
  input  logic pulse_mode,
  input  logic tmr_pulse,
  output logic int_n
);
  logic timer_req;
  logic alarm_req;

  assign alarm_req = aie & af;
  assign timer_req = tie & (pulse_mode ? tmr_pulse : tf);

  always_ff @(posedge clk) begin
    if (rst) int_n <= 1'b1;
    else     int_n <= ~(alarm_req | timer_req);
  end

  // R10: the alarm term holds the line low in either mode
  a_r10_alarm_level: assert property (@(posedge clk) disable iff (rst)
    (aie && af) |=> !int_n);
  // R9: with no enabled source the line is released next cycle
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    (!aie && !tie) |=> int_n);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [6:0]                  cur_min,
  input  logic [5:0]                  cur_hour,
  input  logic [5:0]                  cur_day,
  input  logic [2:0]                  cur_wday,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [REG_W-1:0]            wr_data,
  input  logic                        tmr_expire,
  input  logic                        tmr_pulse,
  output logic [CTRL_W-1:0]           ctrl_q,
  output logic [NUM_FIELDS*REG_W-1:0] alarm_q,
  output logic                        int_n
);
  areg_t cur [NUM_FIELDS];
  logic  match_rise;
  logic  wr_ctrl;

  assign cur[0]  = areg_t'(cur_min);
  assign cur[1]  = areg_t'(cur_hour);
  assign cur[2]  = areg_t'(cur_day);
  assign cur[3]  = areg_t'(cur_wday);
  assign wr_ctrl = wr_en && (wr_sel == '0);

  rtc_alarm_match #(.SEL_W(SEL_W)) u_match (
    .clk        (clk),
    .rst        (rst),
    .cur        (cur),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .alarm_q    (alarm_q),
    .match_rise (match_rise)
  );

  rtc_flag_regs u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (wr_ctrl),
    .wr_data   (wr_data),
    .alarm_set (match_rise),
    .timer_set (tmr_expire),
    .ctrl_q    (ctrl_q)
  );

  rtc_irq_out u_irq (
    .clk        (clk),
    .rst        (rst),
    .af         (ctrl_q[C_AF]),
    .tf         (ctrl_q[C_TF]),
    .aie        (ctrl_q[C_AIE]),
    .tie        (ctrl_q[C_TIE]),
    .pulse_mode (ctrl_q[C_PULSE]),
    .tmr_pulse  (tmr_pulse),
    .int_n      (int_n)
  );
endmodule

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  cur_min = '0;
  logic [5:0]  cur_hour = '0;
  logic [5:0]  cur_day = '0;
  logic [2:0]  cur_wday = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        tmr_expire = 1'b0;
  logic        tmr_pulse = 1'b0;
  logic [4:0]  ctrl_q;
  logic [31:0] alarm_q;
  logic        int_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [6:0] A_MIN = 7'h30, D_MIN = 7'h31;
  localparam logic [5:0] A_HR = 6'h12, D_HR = 6'h13;
  localparam logic [5:0] A_DAY = 6'h15, D_DAY = 6'h16;
  localparam logic [2:0] A_WD = 3'd3, D_WD = 3'd4;

  always #10 clk = ~clk;

  rtc_alarm_irq u_dut (
    .clk(clk), .rst(rst), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_day(cur_day), .cur_wday(cur_wday), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tmr_expire(tmr_expire), .tmr_pulse(tmr_pulse),
    .ctrl_q(ctrl_q), .alarm_q(alarm_q), .int_n(int_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [3:0] eq);
    cur_min  = eq[0] ? A_MIN : D_MIN;
    cur_hour = eq[1] ? A_HR  : D_HR;
    cur_day  = eq[2] ? A_DAY : D_DAY;
    cur_wday = eq[3] ? A_WD  : D_WD;
  endtask

  task automatic load_alarms(input logic [3:0] en);
    wr(3'd1, {~en[0], A_MIN});
    wr(3'd2, {~en[1], 1'b0, A_HR});
    wr(3'd3, {~en[2], 1'b0, A_DAY});
    wr(3'd4, {~en[3], 4'b0, A_WD});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ctrl", 32'(ctrl_q), 32'h0);
    chk("R1 alarms", alarm_q, 32'h80808080);
    chk("R1 int_n", 32'(int_n), 32'h1);

    // R2 R3 R4: every enable mask against every equality pattern
    for (int m = 0; m < 16; m++) begin
      set_time(4'h0);
      load_alarms(4'(m));
      chk("R2 alarm readback", alarm_q,
          {~m[3], 4'b0, A_WD, ~m[2], 1'b0, A_DAY, ~m[1], 1'b0, A_HR, ~m[0], A_MIN});
      for (int e = 0; e < 16; e++) begin
        set_time(4'h0);
        tick();
        wr(3'd0, 8'h00);
        set_time(4'(e));
        tick();
        chk(m == 0 ? "R4 no field enabled" : "R3 match sets flag",
            32'(ctrl_q[0]), 32'((m != 0) && ((e & m) == m)));
      end
    end

    // R5: clearing while the match persists, then a fresh match
    load_alarms(4'hF);
    set_time(4'h0); tick();
    set_time(4'hF); tick();
    chk("R5 first set", 32'(ctrl_q[0]), 32'h1);
    wr(3'd0, 8'h00);
    repeat (3) tick();
    chk("R5 held match stays clear", 32'(ctrl_q[0]), 32'h0);
    set_time(4'h7); tick();
    set_time(4'hF); tick();
    chk("R5 new match sets", 32'(ctrl_q[0]), 32'h1);

    // R6: expiry strobe sets the timer flag
    tmr_expire = 1'b1; tick(); tmr_expire = 1'b0;
    chk("R6 timer flag", 32'(ctrl_q[1]), 32'h1);

    // R7: writing 1 keeps, writing 0 clears only that flag
    wr(3'd0, 8'h03);
    chk("R7 ones keep flags", 32'(ctrl_q), 32'h03);
    wr(3'd0, 8'h02);
    chk("R7 clear alarm keeps timer", 32'(ctrl_q), 32'h02);
    wr(3'd0, 8'h1D);
    chk("R7 enables loaded, timer cleared, alarm not set", 32'(ctrl_q), 32'h1C);
    wr(3'd0, 8'h00);

    // R8: set event collides with a clearing write
    set_time(4'h0); tick();
    tmr_expire = 1'b1; tick(); tmr_expire = 1'b0;
    set_time(4'hF); tmr_expire = 1'b1;
    wr(3'd0, 8'h00);
    tmr_expire = 1'b0;
    chk("R8 both flags survive clear", 32'(ctrl_q[1:0]), 32'h3);

    // R9 R11: level mode interrupt
    wr(3'd0, 8'h0B);          // timer enable, flags kept
    chk("R11 int_n not yet updated", 32'(int_n), 32'h1);
    tick();
    chk("R9 timer level int", 32'(int_n), 32'h0);
    wr(3'd0, 8'h01);          // clear TF, drop enables
    tick();
    chk("R9 disabled releases", 32'(int_n), 32'h1);
    wr(3'd0, 8'h05);          // alarm enable, AF still 1
    tick();
    chk("R9 alarm level int", 32'(int_n), 32'h0);
    wr(3'd0, 8'h04); tick();
    chk("R9 alarm cleared releases", 32'(int_n), 32'h1);

    // R10: pulse mode
    tmr_expire = 1'b1; tick(); tmr_expire = 1'b0;
    wr(3'd0, 8'h1A);          // pulse, timer enable, TF kept, AF clear
    tick();
    chk("R10 TF ignored in pulse mode", 32'(int_n), 32'h1);
    tmr_pulse = 1'b1; tick();
    tmr_pulse = 1'b0;
    chk("R10 pulse drives int", 32'(int_n), 32'h0);
    tick();
    chk("R10 pulse ends", 32'(int_n), 32'h1);
    set_time(4'h0); tick();
    set_time(4'hF); tick();
    wr(3'd0, 8'h17);          // pulse, alarm enable, both flags kept
    repeat (3) tick();
    chk("R10 alarm stays level in pulse mode", 32'(int_n), 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule